// File: doc/BRIEF.md
# Program-Counter Breakpoint Match Unit

This block watches a processor subsystem's bus and raises a break interrupt when an access hits a programmed address. It has a parameterised number of identical channels, two by default. Each channel holds a break address register and a control register. The control register selects four things: the bus master that may trigger the channel, how many low address bits the comparison ignores, the kind of access that counts, and whether a hit requests an interrupt.

Data-read and data-write breaks take effect at the end of the matching bus cycle. An instruction-fetch break behaves differently. A matching fetch only arms the channel. The hit is recorded when the instruction-boundary strobe reports that the instruction at that address is about to execute. A hit sets a sticky flag that software can read. The flag can be cleared only by a read-then-write-zero sequence. A module-stop input freezes every channel.

Software programs the registers through a simple strobe port. The break address for a fetch break is the address of the first byte of the instruction. The interrupt output goes to a separate priority controller.

Top module: `pcbrk_unit`

## Requirements
- R1: After reset, every address register and control register reads as zero, and irq is low.
- R2: A fetch break uses condition code 00. The bus_kind codes are 00 fetch, 01 read, 10 write and 11 none. A fetch break arms the channel when three things hold: a fetch is seen with bus_master 0, the channel's master select is 0, and the address matches. A fetch by itself never sets the flag. The flag is set at the edge where exec_valid presents a matching exec_addr while the channel is armed, and it becomes visible in the next cycle.
- R3: When the master select is 1, condition code 00 never matches, whoever fetches.
- R4: Condition codes 01, 10 and 11 match a read, a write, or either. The access must come from the bus_master value equal to control bit 6. The flag is set at the edge of the matching bus_valid cycle and is visible in the next cycle, not before.
- R5: The mask code in control bits 5:3 sets how many low address bits the comparison ignores:
  - codes 000 to 100 ignore that many bits (0 to 4);
  - code 101 ignores 8 bits;
  - code 110 ignores 12 bits;
  - code 111 ignores 16 bits.
- R6: irq is high exactly when some channel has both its flag and its enable (control bit 0) set, and the module is not stopped. A flag can be set while the enable is 0, and it raises irq as soon as the enable is written to 1.
- R7: The flag is sticky. Writing the control register with bit 7 = 0 clears the flag only if the control register was read (reg_rd) while the flag was 1, after the flag was last set. Writing bit 7 = 1 never clears it.
- R8: If a hit and a valid clear fall in the same cycle, the hit wins and the flag stays 1.
- R9: While mod_stop is 1:
  - no access matches, and an armed fetch break is discarded;
  - register writes are ignored and reads return 0;
  - irq is low, and the flags hold their value.
- R10: Channels are independent. Writing either register of a channel discards that channel's armed fetch break.
- R11: Register map:
  - reg_addr bit 0 selects the address register (0) or the control register (1);
  - the upper bits of reg_addr select the channel;
  - the control byte is laid out as flag in bit 7, master select in bit 6, mask code in bits 5:3, condition in bits 2:1 and enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_stop | input | 1 | Module stop: freezes the block when 1 |
| reg_addr | input | RAW | Register select (bit 0 address/control, upper bits channel) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr |
| bus_valid | input | 1 | Monitored bus cycle completes this cycle |
| bus_addr | input | AW | Monitored access address |
| bus_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| bus_master | input | 1 | 0 processor, 1 other master |
| exec_valid | input | 1 | Instruction-boundary strobe |
| exec_addr | input | AW | Address of the instruction about to execute |
| irq | output | 1 | Break interrupt request |

## Verification
Two functions can land on the same edge:
- a hit setting a channel's flag while software's clearing write reaches that same channel;
- a new fetch arming a channel at the edge where an earlier armed fetch fires.

The first case is provoked directly. The bench reads the flag so that clearing is armed, then drives the clearing write and a matching data access in the same cycle. It judges the result through irq and a later read-back, which must still show the flag set. The random phase mixes clearing writes, reads, bus cycles and execution strobes. A bench model built from the requirements judges every cycle's irq and every read-back, so other collisions are covered too.

// File: rtl/pcbrk_pkg.sv
`timescale 1ns/1ps
package pcbrk_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH = 2'b00,
      KIND_READ  = 2'b01,
      KIND_WRITE = 2'b10,
      KIND_IDLE  = 2'b11
   } bus_kind_e;

   typedef enum logic [1:0] {
      COND_FETCH = 2'b00,
      COND_READ  = 2'b01,
      COND_WRITE = 2'b10,
      COND_RDWR  = 2'b11
   } brk_cond_e;

   // control byte below the flag bit: msel[6] amask[5:3] cond[2:1] ie[0]
   typedef struct packed {
      logic       msel;
      logic [2:0] amask;
      brk_cond_e  cond;
      logic       ie;
   } brk_ctrl_t;

   localparam int CTRL_W   = $bits(brk_ctrl_t);
   localparam int FLAG_BIT = CTRL_W;
   localparam int MAX_IGN  = 16;

   // number of low address bits ignored for a mask code
   function automatic int mask_width(input logic [2:0] code);
      case (code)
         3'd5:    return 8;
         3'd6:    return 12;
         3'd7:    return MAX_IGN;
         default: return int'(code);
      endcase
   endfunction

endpackage

// File: rtl/pcbrk_mask_dec.sv
`timescale 1ns/1ps
module pcbrk_mask_dec
   import pcbrk_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic [2:0]    code,
   output logic [AW-1:0] ignore
);

   always_comb begin
      int n;
      n = mask_width(code);
      for (int i = 0; i < AW; i++) begin
         ignore[i] = (i < n);
      end
   end

endmodule

// File: rtl/pcbrk_addr_cmp.sv
`timescale 1ns/1ps
module pcbrk_addr_cmp #(
   parameter int AW = 24
) (
   input  logic [AW-1:0] probe,
   input  logic [AW-1:0] ref_addr,
   input  logic [AW-1:0] ignore,
   output logic          hit
);

   logic [AW-1:0] diff;

   always_comb begin
      diff = (probe ^ ref_addr) & ~ignore;
      hit  = (diff == '0);
   end

endmodule

// File: rtl/pcbrk_chan.sv
`timescale 1ns/1ps
module pcbrk_chan
   import pcbrk_pkg::*;
#(
   parameter int AW          = 24,
   parameter bit DEFER_FETCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop,
   input  logic          wr_bar,
   input  logic          wr_ctrl,
   input  logic          rd_ctrl,
   input  logic [AW-1:0] wdata,
   input  logic          bus_valid,
   input  logic [AW-1:0] bus_addr,
   input  logic [1:0]    bus_kind,
   input  logic          bus_master,
   input  logic          exec_valid,
   input  logic [AW-1:0] exec_addr,
   output logic [AW-1:0] bar_q,
   output brk_ctrl_t     ctrl_q,
   output logic          flag_q,
   output logic          req
);

   logic [AW-1:0] ignore;
   logic          bus_hit;
   logic          kind_ok;
   logic          fetch_hit;
   logic          data_hit;
   logic          exec_fire;
   logic          hit_set;
   logic          clr_try;
   logic          armed_q;
   bus_kind_e     kind;

   pcbrk_mask_dec #(.AW(AW)) u_mask (
      .code   (ctrl_q.amask),
      .ignore (ignore)
   );

   pcbrk_addr_cmp #(.AW(AW)) u_bus_cmp (
      .probe    (bus_addr),
      .ref_addr (bar_q),
      .ignore   (ignore),
      .hit      (bus_hit)
   );

   always_comb begin
      kind = bus_kind_e'(bus_kind);
      case (ctrl_q.cond)
         COND_READ:  kind_ok = (kind == KIND_READ);
         COND_WRITE: kind_ok = (kind == KIND_WRITE);
         COND_RDWR:  kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
         default:    kind_ok = 1'b0;
      endcase
      fetch_hit = !stop && bus_valid && (kind == KIND_FETCH) &&
                  (ctrl_q.cond == COND_FETCH) && !ctrl_q.msel &&
                  !bus_master && bus_hit;
      data_hit  = !stop && bus_valid && kind_ok &&
                  (bus_master == ctrl_q.msel) && bus_hit;
   end

   generate
      if (DEFER_FETCH) begin : g_defer
         logic pend_q;
         logic exec_hit;

         pcbrk_addr_cmp #(.AW(AW)) u_exec_cmp (
            .probe    (exec_addr),
            .ref_addr (bar_q),
            .ignore   (ignore),
            .hit      (exec_hit)
         );

         assign exec_fire = !stop && exec_valid && pend_q && exec_hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (stop || wr_bar || wr_ctrl) begin
               pend_q <= 1'b0;
            end else if (fetch_hit) begin
               pend_q <= 1'b1;
            end else if (exec_fire) begin
               pend_q <= 1'b0;
            end
         end
      end else begin : g_direct
         assign exec_fire = fetch_hit;
      end
   endgenerate

   assign hit_set = data_hit || exec_fire;
   assign clr_try = wr_ctrl && !wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_q <= '0;
      end else if (wr_bar) begin
         bar_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= brk_ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit_set) begin
         flag_q <= 1'b1;
      end else if (clr_try && armed_q) begin
         flag_q <= 1'b0;
      end
   end

   // clearing is armed by a read that saw the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         armed_q <= flag_q && !clr_try && (armed_q || rd_ctrl);
      end
   end

   assign req = flag_q && ctrl_q.ie;

endmodule

// File: rtl/pcbrk_unit.sv
`timescale 1ns/1ps
module pcbrk_unit
   import pcbrk_pkg::*;
#(
   parameter int  AW          = 24,
   parameter int  NCH         = 2,
   parameter bit  DEFER_FETCH = 1'b1,
   localparam int CHW         = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int RAW         = CHW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mod_stop,
   input  logic [RAW-1:0] reg_addr,
   input  logic           reg_wr,
   input  logic           reg_rd,
   input  logic [AW-1:0]  reg_wdata,
   output logic [AW-1:0]  reg_rdata,
   input  logic           bus_valid,
   input  logic [AW-1:0]  bus_addr,
   input  logic [1:0]     bus_kind,
   input  logic           bus_master,
   input  logic           exec_valid,
   input  logic [AW-1:0]  exec_addr,
   output logic           irq
);

   localparam int CFG_W = AW + CTRL_W;

   generate
      if (AW < MAX_IGN || AW < CTRL_W + 1) begin : g_bad_aw
         $error("pcbrk_unit: AW must cover the widest mask and the control byte");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("pcbrk_unit: NCH must be at least 1");
      end
   endgenerate

   logic [AW-1:0]        bar_v [NCH];
   brk_ctrl_t            ctrl_v [NCH];
   logic [NCH-1:0]       req_v;
   logic [NCH-1:0]       flag_vec;
   logic [NCH*CFG_W-1:0] cfg_vec;
   logic                 acc_wr;
   logic                 acc_rd;
   logic [CHW-1:0]       ch_idx;

   assign acc_wr = reg_wr && !mod_stop;
   assign acc_rd = reg_rd && !mod_stop;
   assign ch_idx = reg_addr[RAW-1:1];

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic sel;
      assign sel = (ch_idx == CHW'(g));

      pcbrk_chan #(.AW(AW), .DEFER_FETCH(DEFER_FETCH)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .stop       (mod_stop),
         .wr_bar     (acc_wr && sel && !reg_addr[0]),
         .wr_ctrl    (acc_wr && sel && reg_addr[0]),
         .rd_ctrl    (acc_rd && sel && reg_addr[0]),
         .wdata      (reg_wdata),
         .bus_valid  (bus_valid),
         .bus_addr   (bus_addr),
         .bus_kind   (bus_kind),
         .bus_master (bus_master),
         .exec_valid (exec_valid),
         .exec_addr  (exec_addr),
         .bar_q      (bar_v[g]),
         .ctrl_q     (ctrl_v[g]),
         .flag_q     (flag_vec[g]),
         .req        (req_v[g])
      );

      assign cfg_vec[g*CFG_W +: CFG_W] = {bar_v[g], ctrl_v[g]};
   end

   always_comb begin
      reg_rdata = '0;
      if (!mod_stop) begin
         for (int i = 0; i < NCH; i++) begin
            if (ch_idx == CHW'(i)) begin
               reg_rdata = reg_addr[0] ? AW'({flag_vec[i], ctrl_v[i]}) : bar_v[i];
            end
         end
      end
   end

   assign irq = !mod_stop && (|req_v);

endmodule

// File: rtl/pcbrk_unit_chk.sv
`timescale 1ns/1ps
module pcbrk_unit_chk #(
   parameter int AW          = 24,
   parameter int NCH         = 2,
   parameter bit DEFER_FETCH = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   mod_stop,
   input logic                   reg_wr,
   input logic                   bus_valid,
   input logic [1:0]             bus_kind,
   input logic                   exec_valid,
   input logic                   irq,
   input logic [NCH-1:0]         flag_vec,
   input logic [NCH*(AW+7)-1:0]  cfg_vec
);

   assert_stop_holds_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mod_stop |=> $stable(flag_vec));

   assert_stop_holds_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mod_stop |=> $stable(cfg_vec));

   assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_vec != '0));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

   // a new flag needs a completed data access or an execution strobe one edge earlier
   assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_vec & ~$past(flag_vec)) != '0) |->
         (!DEFER_FETCH || $past(exec_valid || (bus_valid && bus_kind != 2'b00))));

endmodule

bind pcbrk_unit pcbrk_unit_chk #(.AW(AW), .NCH(NCH), .DEFER_FETCH(DEFER_FETCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mod_stop   (mod_stop),
   .reg_wr     (reg_wr),
   .bus_valid  (bus_valid),
   .bus_kind   (bus_kind),
   .exec_valid (exec_valid),
   .irq        (irq),
   .flag_vec   (flag_vec),
   .cfg_vec    (cfg_vec)
);

// File: tb/pcbrk_unit_bench.sv
`timescale 1ns/1ps
module pcbrk_unit_bench;

   localparam int AW  = 24;
   localparam int NCH = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mod_stop;
   logic [1:0]    reg_addr;
   logic          reg_wr;
   logic          reg_rd;
   logic [AW-1:0] reg_wdata;
   logic [AW-1:0] reg_rdata;
   logic          bus_valid;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_kind;
   logic          bus_master;
   logic          exec_valid;
   logic [AW-1:0] exec_addr;
   logic          irq;

   always #2 clk = ~clk;

   pcbrk_unit u_pcbrk_unit (
      .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
      .bus_master(bus_master), .exec_valid(exec_valid), .exec_addr(exec_addr),
      .irq(irq)
   );

   int n_chk = 0;
   int n_err = 0;

   // reference model, built from the requirements
   logic [AW-1:0] m_bar  [NCH];
   logic [6:0]    m_ctrl [NCH];
   logic          m_flag [NCH];
   logic          m_arm  [NCH];
   logic          m_pend [NCH];

   function automatic logic [AW-1:0] f_mask(input logic [2:0] c);
      int n;
      logic [AW-1:0] m;
      n = (c == 3'd5) ? 8 : (c == 3'd6) ? 12 : (c == 3'd7) ? 16 : int'(c);
      m = '0;
      for (int i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic f_hit(input int ch, input logic [AW-1:0] a);
      return ((a ^ m_bar[ch]) & ~f_mask(m_ctrl[ch][5:3])) == '0;
   endfunction

   function automatic logic f_irq();
      logic r;
      r = 1'b0;
      for (int c = 0; c < NCH; c++) r = r | (m_flag[c] & m_ctrl[c][0]);
      return r & !mod_stop;
   endfunction

   function automatic logic [AW-1:0] f_rd(input logic [1:0] a);
      if (mod_stop) return '0;
      if (a[0]) return AW'({m_flag[a[1]], m_ctrl[a[1]]});
      return m_bar[a[1]];
   endfunction

   task automatic model_step();
      for (int c = 0; c < NCH; c++) begin
         logic sel, wb, wc, rc, fh, ko, dh, ef, ct, nf, na, np;
         logic [1:0] cond;
         logic msel;
         sel  = (int'(reg_addr[1]) == c);
         wb   = !mod_stop && reg_wr && sel && !reg_addr[0];
         wc   = !mod_stop && reg_wr && sel && reg_addr[0];
         rc   = !mod_stop && reg_rd && sel && reg_addr[0];
         cond = m_ctrl[c][2:1];
         msel = m_ctrl[c][6];
         fh = !mod_stop && bus_valid && bus_kind == 2'b00 && cond == 2'b00 &&
              !msel && !bus_master && f_hit(c, bus_addr);
         ko = (cond == 2'b01 && bus_kind == 2'b01) || (cond == 2'b10 && bus_kind == 2'b10) ||
              (cond == 2'b11 && (bus_kind == 2'b01 || bus_kind == 2'b10));
         dh = !mod_stop && bus_valid && ko && bus_master == msel && f_hit(c, bus_addr);
         ef = !mod_stop && exec_valid && m_pend[c] && f_hit(c, exec_addr);
         ct = wc && !reg_wdata[7];
         nf = (dh || ef) ? 1'b1 : (ct && m_arm[c]) ? 1'b0 : m_flag[c];
         na = m_flag[c] && !ct && (m_arm[c] || rc);
         np = (wb || wc || mod_stop) ? 1'b0 : fh ? 1'b1 : ef ? 1'b0 : m_pend[c];
         m_flag[c] = nf;
         m_arm[c]  = na;
         m_pend[c] = np;
         if (wb) m_bar[c] = reg_wdata;
         if (wc) m_ctrl[c] = reg_wdata[6:0];
      end
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock: inputs already driven after a falling edge
   task automatic cyc(input string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk({31'd0, irq}, {31'd0, f_irq()}, {tag, " irq"});
      reg_wr = 1'b0; reg_rd = 1'b0; bus_valid = 1'b0; exec_valid = 1'b0;
      bus_kind = 2'b11;
   endtask

   task automatic wr(input logic [1:0] a, input logic [AW-1:0] d, input string tag);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      cyc(tag);
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      reg_addr = a; reg_rd = 1'b1;
      #1;
      chk(32'(reg_rdata), 32'(f_rd(a)), {tag, " rdata"});
      cyc(tag);
   endtask

   task automatic bus(input logic [AW-1:0] a, input logic [1:0] k, input logic m, input string tag);
      bus_valid = 1'b1; bus_addr = a; bus_kind = k; bus_master = m;
      #1;
      chk({31'd0, irq}, {31'd0, f_irq()}, {tag, " before edge"});
      cyc(tag);
   endtask

   task automatic exc(input logic [AW-1:0] a, input string tag);
      exec_valid = 1'b1; exec_addr = a;
      cyc(tag);
   endtask

   task automatic clear_all();
      for (int c = 0; c < NCH; c++) begin
         rd(2'(2*c+1), "R7 clear read");
         wr(2'(2*c+1), AW'(m_ctrl[c]), "R7 clear write");
         wr(2'(2*c+1), '0, "R7 disable");
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual expired expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_bar[c] = '0; m_ctrl[c] = '0; m_flag[c] = 0; m_arm[c] = 0; m_pend[c] = 0;
      end
      rst_n = 1'b0; mod_stop = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0;
      reg_wdata = '0; bus_valid = 0; bus_addr = '0; bus_kind = 2'b11; bus_master = 0;
      exec_valid = 0; exec_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({31'd0, irq}, 32'd0, "R1 irq after reset");
      for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset read");

      // R2 fetch break deferred to execution, channel A, ctrl 0x01
      wr(2'd0, 24'h001234, "R11 bar A");
      wr(2'd1, 24'h000001, "R11 ctrl A");
      bus(24'h001234, 2'b00, 1'b0, "R2 fetch");
      chk({31'd0, irq}, 32'd0, "R2 fetch alone no irq");
      cyc("R2 idle");
      exc(24'h001230, "R2 exec other addr");
      chk({31'd0, irq}, 32'd0, "R2 exec mismatch");
      exc(24'h001234, "R2 exec match");
      chk({31'd0, irq}, 32'd1, "R2 exec match irq");

      // R7 clearing protocol
      wr(2'd1, 24'h000001, "R7 clear without read");
      chk({31'd0, irq}, 32'd1, "R7 unarmed clear ignored");
      rd(2'd1, "R7 read flag");
      wr(2'd1, 24'h000081, "R7 write one");
      chk({31'd0, irq}, 32'd1, "R7 write one keeps flag");
      wr(2'd1, 24'h000001, "R7 armed clear");
      chk({31'd0, irq}, 32'd0, "R7 cleared");

      // R3 fetch with other master selected, ctrl 0x41
      wr(2'd1, 24'h000041, "R3 ctrl");
      bus(24'h001234, 2'b00, 1'b0, "R3 fetch cpu");
      bus(24'h001234, 2'b00, 1'b1, "R3 fetch other");
      exc(24'h001234, "R3 exec");
      chk({31'd0, irq}, 32'd0, "R3 never matches");

      // R5 mask codes: read break 0x2B ignores 8 bits, 0x3B ignores 16 bits
      wr(2'd0, 24'h5A5A5A, "R5 bar");
      wr(2'd1, 24'h00002B, "R5 ctrl 8 bits");
      bus(24'h5A5AFF, 2'b01, 1'b0, "R5 low 8 differ");
      chk({31'd0, irq}, 32'd1, "R5 masked match");
      clear_all();
      wr(2'd1, 24'h00002B, "R5 ctrl 8 bits again");
      bus(24'h5A5B5A, 2'b01, 1'b0, "R5 bit 8 differs");
      chk({31'd0, irq}, 32'd0, "R5 unmasked bit blocks");
      wr(2'd1, 24'h00003B, "R5 ctrl 16 bits");
      bus(24'h5B5A5A, 2'b01, 1'b0, "R5 bit 16 differs");
      chk({31'd0, irq}, 32'd0, "R5 bit 16 blocks");
      bus(24'h5AFFFF, 2'b01, 1'b0, "R5 low 16 differ");
      chk({31'd0, irq}, 32'd1, "R5 16-bit mask match");
      clear_all();

      // R4 write break by other master, ctrl 0x45
      wr(2'd0, 24'h00A000, "R4 bar");
      wr(2'd1, 24'h000045, "R4 ctrl");
      bus(24'h00A000, 2'b10, 1'b0, "R4 wrong master");
      bus(24'h00A000, 2'b01, 1'b1, "R4 wrong kind");
      chk({31'd0, irq}, 32'd0, "R4 no match yet");
      bus(24'h00A000, 2'b10, 1'b1, "R4 write match");
      chk({31'd0, irq}, 32'd1, "R4 match next cycle");
      clear_all();

      // R6 flag with enable off (ctrl 0x06), then enable
      wr(2'd0, 24'h00A000, "R6 bar");
      wr(2'd1, 24'h000006, "R6 ctrl ie0");
      bus(24'h00A000, 2'b01, 1'b0, "R6 read match");
      chk({31'd0, irq}, 32'd0, "R6 no irq when disabled");
      reg_addr = 2'd1; #1;
      chk(32'(reg_rdata), 32'h86, "R6 flag visible");
      reg_addr = 2'd0;
      wr(2'd1, 24'h000007, "R6 enable");
      chk({31'd0, irq}, 32'd1, "R6 irq on enable");

      // R8 hit and armed clear in the same cycle
      rd(2'd1, "R8 arm");
      reg_addr = 2'd1; reg_wdata = 24'h000007; reg_wr = 1'b1;
      bus_valid = 1'b1; bus_addr = 24'h00A000; bus_kind = 2'b01; bus_master = 1'b0;
      cyc("R8 collide");
      chk({31'd0, irq}, 32'd1, "R8 set wins");
      rd(2'd1, "R8 readback");

      // R9 module stop
      mod_stop = 1'b1; #1;
      chk({31'd0, irq}, 32'd0, "R9 irq low in stop");
      rd(2'd1, "R9 read zero");
      wr(2'd0, 24'hFFFFFF, "R9 write ignored");
      clear_all();
      mod_stop = 1'b0;
      cyc("R9 release");
      rd(2'd0, "R9 bar kept");
      chk({31'd0, irq}, 32'd1, "R9 flag held");
      clear_all();
      wr(2'd2, 24'h000400, "R9 bar B");
      wr(2'd3, 24'h000001, "R9 ctrl B");
      bus(24'h000400, 2'b00, 1'b0, "R9 fetch");
      mod_stop = 1'b1;
      cyc("R9 stop cycle");
      mod_stop = 1'b0;
      exc(24'h000400, "R9 exec after stop");
      chk({31'd0, irq}, 32'd0, "R9 pending discarded");

      // R10 write discards armed fetch; channels independent
      bus(24'h000400, 2'b00, 1'b0, "R10 fetch B");
      wr(2'd2, 24'h000400, "R10 rewrite bar B");
      exc(24'h000400, "R10 exec");
      chk({31'd0, irq}, 32'd0, "R10 pending discarded");
      wr(2'd0, 24'h000400, "R10 bar A");
      wr(2'd1, 24'h000007, "R10 ctrl A");
      bus(24'h000400, 2'b01, 1'b0, "R10 read A");
      rd(2'd3, "R10 B unaffected");
      clear_all();

      // random phase
      void'($urandom(32'd20241));
      for (int i = 0; i < 3000; i++) begin
         int p;
         if (i % 150 == 0) begin
            for (int c = 0; c < NCH; c++) begin
               wr(2'(2*c), AW'($urandom), "R5 rand bar");
               wr(2'(2*c+1), AW'($urandom % 128), "R4 rand ctrl");
            end
         end
         p = int'($urandom % 100);
         if (p < 3) mod_stop = !mod_stop;
         if ($urandom % 2 == 0) begin
            int c = int'($urandom % NCH);
            bus_valid = 1'b1;
            bus_addr = m_bar[c] ^ AW'($urandom % (($urandom % 2) ? 24'h20 : 24'h20000));
            bus_kind = 2'($urandom);
            bus_master = ($urandom % 4 == 0);
         end
         if ($urandom % 4 == 0) begin
            int c = int'($urandom % NCH);
            exec_valid = 1'b1;
            exec_addr = m_bar[c] ^ AW'($urandom % 24'h40);
         end
         p = int'($urandom % 100);
         if (p < 8) begin
            int c = int'($urandom % NCH);
            reg_addr = 2'(2*c+1); reg_rd = 1'b1; #1;
            chk(32'(reg_rdata), 32'(f_rd(reg_addr)), "R11 rand read");
         end else if (p < 12) begin
            int c = int'($urandom % NCH);
            reg_addr = 2'(2*c+1); reg_wr = 1'b1;
            reg_wdata = AW'(m_ctrl[c]);
         end
         cyc("R8 rand");
      end
      mod_stop = 1'b0;
      for (int a = 0; a < 4; a++) rd(2'(a), "R11 final read");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule